// File: doc/BRIEF.md
# Quarter-Phase Coarse Interval Counter

This block produces the coarse part of a start-to-stop time measurement. A 16-bit counter runs freely on the main clock. An external front end samples the START and STOP signals on four copies of that clock, shifted by 0°, 90°, 180° and 270°, and delivers each set of four samples to the block in the main clock domain. For each channel the block finds the cycle in which the signal rises, takes the quarter of the period in which the rise occurred, and forms an 18-bit timestamp. The counter value sits in the upper 16 bits and the quarter label in the lower 2 bits.

A small capture state machine waits for a START edge and stamps it. It then waits for a STOP edge, stamps that and reports the 18-bit span. The span is the STOP stamp minus the START stamp, in units of a quarter clock period. Each stamp also carries a half-period select bit. A fine interpolator downstream uses that bit to choose which of its two delay lines holds the valid reading for that edge.

Top module: `qtc_coarse_timer`

## Requirements
- R1: After reset the counter is 0. It advances by one on every clock edge with `rst` low and wraps modulo 2^16. A stamp's upper 16 bits equal the count held during the cycle in which the edge was presented.
- R2: A channel sees an edge in a cycle when its 4-bit sample vector is nonzero and bit 3 of that channel's vector in the previous cycle was 0. Bit 0 is the 0° sample, bit 1 is 90°, bit 2 is 180° and bit 3 is 270°. The quarter label is the index of the lowest set bit: 0°→00, 90°→01, 180°→10, 270°→11.
- R3: A START edge loads `t_start` with {count, label}. The new value is visible after the clock edge that sampled it.
- R4: A STOP edge accepted while a measurement is open loads `t_stop` with {count, label} and closes the measurement.
- R5: When a measurement closes, `span` = `t_stop` − `t_start` modulo 2^18. The result is correct when the counter wraps once between the two edges.
- R6: `sel_start` and `sel_stop` equal bit 1 of the matching label. The value is 0 for the 0° and 90° quarters and 1 for the 180° and 270° quarters.
- R7: `done` is high for exactly one cycle, in the cycle after the sampling edge of the accepted STOP edge. `t_stop`, `span` and both select bits are valid at that point and hold until the next measurement closes.
- R8: A STOP edge with no open measurement is ignored. `done` stays low, and `t_stop` and `span` keep their values.
- R9: A START edge while a measurement is open restarts it from the new stamp. A START edge and a STOP edge in the same cycle count as a restart, with no `done`.
- R10: Reset clears `t_start`, `t_stop`, `span`, both select bits and `done` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock (0° phase) |
| rst | input | 1 | Synchronous active-high reset |
| start_ph | input | 4 | START samples at 0°/90°/180°/270° (bits 0..3) |
| stop_ph | input | 4 | STOP samples at 0°/90°/180°/270° (bits 0..3) |
| t_start | output | 18 | START stamp {count, quarter label} |
| t_stop | output | 18 | STOP stamp {count, quarter label} |
| span | output | 18 | Interval in quarter periods, modulo 2^18 |
| sel_start | output | 1 | Delay-line select for the START edge |
| sel_stop | output | 1 | Delay-line select for the STOP edge |
| done | output | 1 | One-cycle strobe when a measurement closes |

## Verification
A counter that slips or resets early shows up in the very next stamp. That stamp no longer matches the bench's own count of clock edges. A wrong open/closed state appears at the ports as a `done` that fires on a STOP edge that should be ignored, or that misses one that should be accepted. The error is visible in the cycle after that STOP edge.

A wrong quarter label or wrong edge detection shows in the two low bits of the stamp and in the select bit. These are visible one cycle after the edge. The long wrap case shows whether the subtraction stays correct across a counter rollover.

// File: rtl/qtc_pkg.sv
package qtc_pkg;

    localparam int CNT_W   = 16;
    localparam int PH_N    = 4;
    localparam int LBL_W   = $clog2(PH_N);
    localparam int STAMP_W = CNT_W + LBL_W;

    typedef logic [CNT_W-1:0]   count_t;
    typedef logic [LBL_W-1:0]   label_t;
    typedef logic [PH_N-1:0]    phase_vec_t;
    typedef logic [STAMP_W-1:0] stamp_t;

    typedef enum logic {
        CAP_IDLE  = 1'b0,
        CAP_ARMED = 1'b1
    } cap_state_t;

    typedef struct packed {
        logic   hit;
        label_t lbl;
    } edge_info_t;

    // index of the earliest phase sample that is high
    function automatic label_t first_high(input phase_vec_t v);
        label_t r;
        r = '0;
        for (int i = PH_N - 1; i >= 0; i--) begin
            if (v[i]) r = label_t'(i);
        end
        return r;
    endfunction

    // label MSB marks the second half of the period
    function automatic logic half_sel(input label_t l);
        return l[LBL_W-1];
    endfunction

endpackage

// File: rtl/qtc_free_counter.sv
module qtc_free_counter
    import qtc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output count_t cnt
);
    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + count_t'(1);
    end
endmodule

// File: rtl/qtc_phase_det.sv
module qtc_phase_det
    import qtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  phase_vec_t ph,
    output edge_info_t info
);
    logic last_high;

    always_ff @(posedge clk) begin
        if (rst) last_high <= 1'b0;
        else     last_high <= ph[PH_N-1];
    end

    always_comb begin
        info.hit = (|ph) && !last_high;
        info.lbl = first_high(ph);
    end
endmodule

// File: rtl/qtc_capture.sv
module qtc_capture
    import qtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  count_t     cnt,
    input  edge_info_t ev_start,
    input  edge_info_t ev_stop,
    output stamp_t     t_start,
    output stamp_t     t_stop,
    output stamp_t     span,
    output logic       sel_start,
    output logic       sel_stop,
    output logic       done
);
    cap_state_t state;
    stamp_t     stop_now;

    assign stop_now = {cnt, ev_stop.lbl};

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= CAP_IDLE;
            t_start   <= '0;
            t_stop    <= '0;
            span      <= '0;
            sel_start <= 1'b0;
            sel_stop  <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (ev_start.hit) begin
                t_start   <= {cnt, ev_start.lbl};
                sel_start <= half_sel(ev_start.lbl);
                state     <= CAP_ARMED;
            end else if (state == CAP_ARMED && ev_stop.hit) begin
                t_stop   <= stop_now;
                sel_stop <= half_sel(ev_stop.lbl);
                span     <= stop_now - t_start;
                done     <= 1'b1;
                state    <= CAP_IDLE;
            end
        end
    end
endmodule

// File: rtl/qtc_coarse_timer.sv
module qtc_coarse_timer
    import qtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [PH_N-1:0]    start_ph,
    input  logic [PH_N-1:0]    stop_ph,
    output logic [STAMP_W-1:0] t_start,
    output logic [STAMP_W-1:0] t_stop,
    output logic [STAMP_W-1:0] span,
    output logic               sel_start,
    output logic               sel_stop,
    output logic               done
);
    localparam int N_CH = 2;

    count_t                     cnt_q;
    edge_info_t [N_CH-1:0]      ev;
    phase_vec_t [N_CH-1:0]      ph_in;

    assign ph_in[0] = start_ph;
    assign ph_in[1] = stop_ph;

    qtc_free_counter u_cnt (
        .clk (clk),
        .rst (rst),
        .cnt (cnt_q)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_det
        qtc_phase_det u_det (
            .clk  (clk),
            .rst  (rst),
            .ph   (ph_in[ch]),
            .info (ev[ch])
        );
    end

    qtc_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .cnt       (cnt_q),
        .ev_start  (ev[0]),
        .ev_stop   (ev[1]),
        .t_start   (t_start),
        .t_stop    (t_stop),
        .span      (span),
        .sel_start (sel_start),
        .sel_stop  (sel_stop),
        .done      (done)
    );
endmodule

// File: rtl/qtc_coarse_timer_chk.sv
module qtc_coarse_timer_chk
    import qtc_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input count_t cnt,
    input stamp_t t_start,
    input stamp_t t_stop,
    input stamp_t span,
    input logic   sel_start,
    input logic   sel_stop,
    input logic   done
);
    logic prev_run = 1'b0;

    always_ff @(posedge clk) prev_run <= !rst;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        prev_run |-> cnt == count_t'($past(cnt) + count_t'(1))); // R1

    AST_START_HOLD: assert property (@(posedge clk) disable iff (rst)
        done |-> $stable(t_start)); // R3

    AST_SPAN_DIFF: assert property (@(posedge clk) disable iff (rst)
        done |-> span == stamp_t'(t_stop - t_start)); // R5

    AST_SEL_MATCH: assert property (@(posedge clk) disable iff (rst)
        done |-> (sel_stop == t_stop[1]) && (sel_start == t_start[1])); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
endmodule

bind qtc_coarse_timer qtc_coarse_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt       (cnt_q),
    .t_start   (t_start),
    .t_stop    (t_stop),
    .span      (span),
    .sel_start (sel_start),
    .sel_stop  (sel_stop),
    .done      (done)
);

// File: tb/qtc_coarse_timer_bench.sv
module qtc_coarse_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  start_ph = 4'h0;
    logic [3:0]  stop_ph  = 4'h0;
    logic [17:0] t_start, t_stop, span;
    logic        sel_start, sel_stop, done;

    int          n_run = 0;
    int          n_fail = 0;
    int unsigned mc = 0;      // bench model of the counter
    logic [17:0] exp_start = '0;
    logic [17:0] exp_stop  = '0;
    logic [17:0] exp_span  = '0;

    always #5 clk = ~clk;

    qtc_coarse_timer u_qtc_coarse_timer (
        .clk(clk), .rst(rst), .start_ph(start_ph), .stop_ph(stop_ph),
        .t_start(t_start), .t_stop(t_stop), .span(span),
        .sel_start(sel_start), .sel_stop(sel_stop), .done(done)
    );

    function automatic logic [3:0] therm(input int p);
        return 4'((4'hF << p) & 4'hF);
    endfunction

    function automatic logic [17:0] stamp(input int unsigned c, input int p);
        return {16'(c), 2'(p)};
    endfunction

    task automatic step();
        @(posedge clk);
        if (rst) mc = 0;
        else     mc = (mc + 1) & 32'hFFFF;
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // start edge at quarter p, then held high one cycle, then low
    task automatic pulse_start(input int p);
        start_ph = therm(p);
        exp_start = stamp(mc, p);
        step();
        start_ph = 4'hF; step();
        start_ph = 4'h0; step();
    endtask

    task automatic pulse_stop_accept(input int p);
        stop_ph = therm(p);
        exp_stop = stamp(mc, p);
        exp_span = exp_stop - exp_start;
        step();
        chk("R7 done", 32'(done), 1);
        chk("R4 t_stop", 32'(t_stop), 32'(exp_stop));
        chk("R5 span", 32'(span), 32'(exp_span));
        chk("R6 sel_stop", 32'(sel_stop), 32'(p >= 2));
        stop_ph = 4'hF; step();
        chk("R7 done one cycle", 32'(done), 0);
        stop_ph = 4'h0; step();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        idle(3);
        chk("R10 t_start", 32'(t_start), 0);
        chk("R10 t_stop", 32'(t_stop), 0);
        chk("R10 span", 32'(span), 0);
        chk("R10 sel", 32'({sel_start, sel_stop}), 0);
        chk("R10 done", 32'(done), 0);
        rst = 1'b0;

        // R8: stop with nothing open
        idle(2);
        stop_ph = therm(1); step();
        chk("R8 no done", 32'(done), 0);
        stop_ph = 4'h0; step();
        chk("R8 t_stop kept", 32'(t_stop), 0);
        chk("R8 span kept", 32'(span), 0);

        // R1/R3: first stamp shows the counter; each quarter label
        for (int p = 0; p < 4; p++) begin
            pulse_start(p);
            chk("R3 t_start", 32'(t_start), 32'(exp_start));
            chk("R2 label", 32'(t_start[1:0]), 32'(p));
            chk("R6 sel_start", 32'(sel_start), 32'(p >= 2));
            idle(p);
            pulse_stop_accept(3 - p);
        end

        // R2: a level held high is not a new edge
        start_ph = therm(2); exp_start = stamp(mc, 2); step();
        start_ph = 4'hF; idle(3);
        chk("R2 held level", 32'(t_start), 32'(exp_start));
        start_ph = 4'h0; step();
        pulse_stop_accept(0);

        // R9: restart by second start
        pulse_start(1);
        idle(4);
        pulse_start(3);
        chk("R9 restamp", 32'(t_start), 32'(exp_start));
        pulse_stop_accept(2);

        // R9: start and stop together while open
        pulse_start(0);
        start_ph = therm(2); stop_ph = therm(1);
        exp_start = stamp(mc, 2);
        step();
        chk("R9 simultaneous no done", 32'(done), 0);
        start_ph = 4'hF; stop_ph = 4'hF; step();
        start_ph = 4'h0; stop_ph = 4'h0; step();
        pulse_stop_accept(1);

        // random measurements
        for (int k = 0; k < 30; k++) begin
            int ps, pe, g;
            ps = int'($urandom % 4);
            pe = int'($urandom % 4);
            g  = int'($urandom % 20);
            pulse_start(ps);
            idle(g);
            pulse_stop_accept(pe);
        end

        // R5: single counter wrap between the edges
        pulse_start(3);
        idle(65500);
        pulse_stop_accept(0);
        chk("R1 wrap stamp", 32'(t_stop[17:2]), 32'(exp_stop[17:2]));

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule